// File: doc/BRIEF.md
# Monitor Control Register File

This block holds the control registers of a hardware monitoring chip behind a byte-wide write/read port. It keeps two configuration registers, a channel mode register, a programmable DAC output byte, two temperature high-limit registers and a chassis-intrusion clear command register. From these it drives the monitoring run/shutdown control, interrupt enables and clear levels, dual-function pin selects, and two timed active-low pulses: one on a reset output and one on a chassis-intrusion reset output.

Three reset sources act on the registers, and each reaches a different set. The asynchronous power-on reset `rst_ni` clears everything, including the write-once lock bits and the DAC byte. The external reset input `ext_rst_ni` passes through a two-flop synchronizer. The self-clearing initialization command in configuration register 1 has the same reach as the external reset. Neither of these two touches the DAC byte, the lock bits or a locked limit register. Register access works whether the monitoring loop is running or shut down.

Top module: `mon_ctrl_regs`

## Requirements
- R1: After power-on reset: cfg1 (40h) reads 08h, so `run_o`=0 and `int_clr_o`=1. cfg2 (41h) and chmode (42h) read 00h. The DAC byte (43h) reads FFh. The limit at 13h reads LIM_INT_DEF (46h) and the limit at 14h reads LIM_EXT_DEF (55h). Both pulse outputs are high.
- R2: A write (`wr_i`=1) takes effect at the next clock edge. `rdata_o` is combinational from `addr_i`. cfg1 stores bits 0,1,2,3,6. cfg2 stores bits 0,1,2,3,6,7. chmode stores bits 3:0. DAC, 13h and 14h store all 8 bits. Bits that are not stored read 0, and 44h always reads 00h.
- R3: A write to cfg1 with bit 7 set returns the following to their R1 values at that edge: cfg1, cfg2 bits 0,3,6,7, chmode, and each limit whose lock bit is clear. The rest of that write is ignored, bit 7 reads back 0, and the DAC byte is unchanged.
- R4: While the synchronized `ext_rst_ni` is low, the registers are held as in R3 and writes are ignored. The input is sampled through two flops, so it takes effect on the third rising edge after it falls.
- R5: cfg2 bit 1 locks 13h and cfg2 bit 2 locks 14h. Writes to a locked limit are ignored. A lock bit can be set by a write but can be cleared only by power-on reset.
- R6: A locked limit and the lock bits keep their values through initialization and external reset.
- R7: The cfg1 bits drive these outputs: bit0 `run_o` (1 = run, 0 = shutdown), bit1 `int_en_o`, bit2 `therm_en_o`, bit3 `int_clr_o`, bit6 `therm_clr_o`. The cfg2 bits drive: bit0 `therm_int_mask_o`, bit3 `therm_acpi_o`, bit6 `irq3_en_o`, bit7 `irq4_en_o`.
- R8: The chmode bits drive: bit0 `ain1_sel_o` (1 analog, 0 fan), bit1 `ain2_sel_o`, bit2 `rtemp2_sel_o` (1 second remote temperature, 0 voltages), bit3 `vcc5_sel_o` (1 = 5 V, 0 = 3.3 V).
- R9: A write to cfg1 with bit 4 set, and bit 7 clear, drives `rst_out_no` low for PULSE_CYC cycles starting after that edge. A new trigger during the pulse restarts the count. Bit 4 reads 0.
- R10: A write to 44h with bit 7 set drives `ci_out_no` low for PULSE_CYC cycles. A new trigger during the pulse restarts the count in the same way as R9.
- R11: Writes to unmapped addresses change nothing, and reads of unmapped addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_ni | input | 1 | Asynchronous active-low external reset request |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| run_o | output | 1 | Monitoring loop run (0 = shutdown) |
| int_en_o | output | 1 | Interrupt output enable |
| therm_en_o | output | 1 | Thermal output enable |
| int_clr_o | output | 1 | Interrupt output clear level |
| therm_clr_o | output | 1 | Thermal output clear level |
| therm_int_mask_o | output | 1 | Keep thermal events off the interrupt output |
| therm_acpi_o | output | 1 | Thermal output in ACPI mode |
| irq3_en_o | output | 1 | Interrupt input 3 enable |
| irq4_en_o | output | 1 | Interrupt input 4 enable |
| ain1_sel_o | output | 1 | Dual pin 1 as analog input |
| ain2_sel_o | output | 1 | Dual pin 2 as analog input |
| rtemp2_sel_o | output | 1 | Second remote temperature channel |
| vcc5_sel_o | output | 1 | 5 V nominal supply range |
| dac_o | output | 8 | Programmed DAC output |
| lim_int_o | output | 8 | Internal temperature high limit |
| lim_ext_o | output | 8 | External temperature high limit |
| rst_out_no | output | 1 | Timed active-low reset pulse |
| ci_out_no | output | 1 | Timed active-low chassis-intrusion reset pulse |

## Verification
The hardest state to reach is one where the three reset sources have left different registers in different states. That is a limit register locked with a non-default value, the other limit unlocked, and a DAC byte that is not FFh, all at the moment an initialization or a synchronized external reset arrives. The stimulus builds this state in order: it writes the limits and the DAC, sets one lock bit, and then tries to clear the lock bit and overwrite the locked limit. It then fires the initialization and later holds the external reset low, and it attempts writes during that hold. A power-on reset in the middle of the run then confirms that only this source clears the locks and restores FFh. A behavioural model tracks every register and both pulse counters and checks all outputs on each clock.

// File: rtl/mon_ctrl_pkg.sv
package mon_ctrl_pkg;
  localparam logic [7:0] ADDR_CFG1    = 8'h40;
  localparam logic [7:0] ADDR_CFG2    = 8'h41;
  localparam logic [7:0] ADDR_CHMODE  = 8'h42;
  localparam logic [7:0] ADDR_DAC     = 8'h43;
  localparam logic [7:0] ADDR_CICLR   = 8'h44;
  localparam logic [7:0] ADDR_LIM_INT = 8'h13;
  localparam logic [7:0] ADDR_LIM_EXT = 8'h14;

  localparam logic [7:0] CFG1_DEF   = 8'h08;
  localparam logic [7:0] CFG1_MASK  = 8'h4F;
  localparam logic [7:0] CFG2_MASK  = 8'hC9;  // stored, non-lock bits
  localparam logic [7:0] LOCK_MASK  = 8'h06;
  localparam logic [7:0] DAC_DEF    = 8'hFF;

  localparam int unsigned B_INIT    = 7;
  localparam int unsigned B_RSTP    = 4;
  localparam int unsigned B_CIP     = 7;
  localparam int unsigned B_LOCK_I  = 1;
  localparam int unsigned B_LOCK_E  = 2;
endpackage

// File: rtl/mon_rst_sync.sv
module mon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], async_ni};
  end

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/mon_pulse_gen.sv
module mon_pulse_gen #(
  parameter int unsigned PULSE_CYC = 4_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_no
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (trig_i)      cnt_q <= CW'(PULSE_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_no = (cnt_q == '0);

  // R9 / R10: trigger drives output low next cycle
  a_r9_pulse_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !pulse_no);
  // R9 / R10: last count without retrigger releases the output
  a_r10_pulse_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1) && !trig_i) |=> pulse_no);
endmodule

// File: rtl/mon_lim_reg.sv
module mon_lim_reg #(
  parameter logic [7:0] DEF = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       lock_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= DEF;
    else if (!lock_i) begin
      if (soft_rst_i)           q_o <= DEF;
      else if (we_i)            q_o <= wdata_i;
    end
  end

  // R5 / R6: a locked limit never changes
  a_r6_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(q_o));
endmodule

// File: rtl/mon_ctrl_regs.sv
module mon_ctrl_regs
  import mon_ctrl_pkg::*;
#(
  parameter int unsigned PULSE_CYC   = 4_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  LIM_INT_DEF = 8'h46,
  parameter logic [7:0]  LIM_EXT_DEF = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       run_o,
  output logic       int_en_o,
  output logic       therm_en_o,
  output logic       int_clr_o,
  output logic       therm_clr_o,
  output logic       therm_int_mask_o,
  output logic       therm_acpi_o,
  output logic       irq3_en_o,
  output logic       irq4_en_o,
  output logic       ain1_sel_o,
  output logic       ain2_sel_o,
  output logic       rtemp2_sel_o,
  output logic       vcc5_sel_o,
  output logic [7:0] dac_o,
  output logic [7:0] lim_int_o,
  output logic [7:0] lim_ext_o,
  output logic       rst_out_no,
  output logic       ci_out_no
);
  localparam int unsigned NLIM = 2;

  logic       ext_ok;
  logic       init_cmd, soft_rst, wr_ok;
  logic [7:0] cfg1_q, cfg2_q, dac_q;
  logic [3:0] chm_q;
  logic       trig_rst, trig_ci;
  logic [7:0] lim_q [NLIM];

  mon_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (ext_rst_ni),
    .sync_o   (ext_ok)
  );

  assign init_cmd = wr_i && (addr_i == ADDR_CFG1) && wdata_i[B_INIT];
  assign soft_rst = !ext_ok || init_cmd;
  assign wr_ok    = wr_i && !soft_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= CFG1_DEF;
      cfg2_q <= '0;
      chm_q  <= '0;
      dac_q  <= DAC_DEF;
    end else if (soft_rst) begin
      cfg1_q <= CFG1_DEF;
      cfg2_q <= cfg2_q & LOCK_MASK;  // locks survive
      chm_q  <= '0;
    end else if (wr_ok) begin
      unique case (addr_i)
        ADDR_CFG1:   cfg1_q <= wdata_i & CFG1_MASK;
        ADDR_CFG2:   cfg2_q <= (wdata_i & CFG2_MASK) | ((cfg2_q | wdata_i) & LOCK_MASK);
        ADDR_CHMODE: chm_q  <= wdata_i[3:0];
        ADDR_DAC:    dac_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    localparam logic [7:0]  DEF  = (g == 0) ? LIM_INT_DEF : LIM_EXT_DEF;
    localparam logic [7:0]  ADDR = (g == 0) ? ADDR_LIM_INT : ADDR_LIM_EXT;
    localparam int unsigned LB   = (g == 0) ? B_LOCK_I : B_LOCK_E;
    mon_lim_reg #(.DEF(DEF)) u_lim (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .lock_i     (cfg2_q[LB]),
      .we_i       (wr_ok && (addr_i == ADDR)),
      .wdata_i    (wdata_i),
      .q_o        (lim_q[g])
    );
  end

  assign trig_rst = wr_ok && (addr_i == ADDR_CFG1)  && wdata_i[B_RSTP];
  assign trig_ci  = wr_ok && (addr_i == ADDR_CICLR) && wdata_i[B_CIP];

  mon_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_rst_pulse (
    .clk_i (clk_i), .rst_ni (rst_ni), .trig_i (trig_rst), .pulse_no (rst_out_no)
  );
  mon_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_ci_pulse (
    .clk_i (clk_i), .rst_ni (rst_ni), .trig_i (trig_ci), .pulse_no (ci_out_no)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CFG1:    rdata_o = cfg1_q;
      ADDR_CFG2:    rdata_o = cfg2_q;
      ADDR_CHMODE:  rdata_o = {4'h0, chm_q};
      ADDR_DAC:     rdata_o = dac_q;
      ADDR_LIM_INT: rdata_o = lim_q[0];
      ADDR_LIM_EXT: rdata_o = lim_q[1];
      default:      rdata_o = 8'h00;
    endcase
  end

  assign run_o            = cfg1_q[0];
  assign int_en_o         = cfg1_q[1];
  assign therm_en_o       = cfg1_q[2];
  assign int_clr_o        = cfg1_q[3];
  assign therm_clr_o      = cfg1_q[6];
  assign therm_int_mask_o = cfg2_q[0];
  assign therm_acpi_o     = cfg2_q[3];
  assign irq3_en_o        = cfg2_q[6];
  assign irq4_en_o        = cfg2_q[7];
  assign ain1_sel_o       = chm_q[0];
  assign ain2_sel_o       = chm_q[1];
  assign rtemp2_sel_o     = chm_q[2];
  assign vcc5_sel_o       = chm_q[3];
  assign dac_o            = dac_q;
  assign lim_int_o        = lim_q[0];
  assign lim_ext_o        = lim_q[1];

  // R5: lock bits are sticky until power-on
  a_r5_lock_int_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg2_q[B_LOCK_I] |=> cfg2_q[B_LOCK_I]);
  a_r5_lock_ext_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg2_q[B_LOCK_E] |=> cfg2_q[B_LOCK_E]);
  // R3 / R4: soft resets leave the DAC byte alone
  a_r3_dac_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> $stable(dac_o));
  // R3 / R4: soft resets stop monitoring and assert interrupt clear
  a_r4_soft_shutdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (!run_o && int_clr_o));
endmodule

// File: tb/test_mon_ctrl_regs.sv
`timescale 1ns/1ps
module test_mon_ctrl_regs;
  localparam int unsigned P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ext_n = 1'b1, wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata, dac, lim_i, lim_e;
  logic run, ien, ten, iclr, tclr, tmask, acpi, irq3, irq4;
  logic a1, a2, rt2, v5, rst_out_n, ci_out_n;

  always #2.5 clk = ~clk;

  mon_ctrl_regs #(.PULSE_CYC(P)) i_mon_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .run_o(run), .int_en_o(ien),
    .therm_en_o(ten), .int_clr_o(iclr), .therm_clr_o(tclr),
    .therm_int_mask_o(tmask), .therm_acpi_o(acpi), .irq3_en_o(irq3),
    .irq4_en_o(irq4), .ain1_sel_o(a1), .ain2_sel_o(a2), .rtemp2_sel_o(rt2),
    .vcc5_sel_o(v5), .dac_o(dac), .lim_int_o(lim_i), .lim_ext_o(lim_e),
    .rst_out_no(rst_out_n), .ci_out_no(ci_out_n)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference
  logic [7:0] m_c1, m_c2, m_ch, m_dac, m_l13, m_l14;
  int m_cr, m_cc;
  bit m_s1, m_s2, m_soft, m_k13, m_k14;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c1 = 8'h08; m_c2 = 0; m_ch = 0; m_dac = 8'hFF;
      m_l13 = 8'h46; m_l14 = 8'h55; m_cr = 0; m_cc = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      m_soft = !m_s2 || (wr && addr == 8'h40 && wdata[7]);
      m_k13 = m_c2[1]; m_k14 = m_c2[2];
      if (m_cr > 0) m_cr--;
      if (m_cc > 0) m_cc--;
      if (m_soft) begin
        m_c1 = 8'h08; m_c2 = m_c2 & 8'h06; m_ch = 0;
        if (!m_k13) m_l13 = 8'h46;
        if (!m_k14) m_l14 = 8'h55;
      end else if (wr) begin
        case (addr)
          8'h40: begin m_c1 = wdata & 8'h4F; if (wdata[4]) m_cr = P; end
          8'h41: m_c2 = (wdata & 8'hC9) | ((m_c2 | wdata) & 8'h06);
          8'h42: m_ch = wdata & 8'h0F;
          8'h43: m_dac = wdata;
          8'h44: if (wdata[7]) m_cc = P;
          8'h13: if (!m_k13) m_l13 = wdata;
          8'h14: if (!m_k14) m_l14 = wdata;
          default: ;
        endcase
      end
      m_s2 = m_s1; m_s1 = ext_n;
    end
  end

  function automatic logic [7:0] m_read(logic [7:0] a);
    case (a)
      8'h40: return m_c1;
      8'h41: return m_c2;
      8'h42: return m_ch;
      8'h43: return m_dac;
      8'h13: return m_l13;
      8'h14: return m_l14;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (step %s) %s act=%h exp=%h", tag, phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "rdata", rdata, m_read(addr));
      chk("R7", "cfg1 outs", {3'b0, tclr, iclr, ten, ien, run},
          {3'b0, m_c1[6], m_c1[3], m_c1[2], m_c1[1], m_c1[0]});
      chk("R7", "cfg2 outs", {4'b0, irq4, irq3, acpi, tmask},
          {4'b0, m_c2[7], m_c2[6], m_c2[3], m_c2[0]});
      chk("R8", "chmode outs", {4'b0, v5, rt2, a2, a1}, m_ch);
      chk("R3", "dac", dac, m_dac);
      chk("R5", "lim 13h", lim_i, m_l13);
      chk("R5", "lim 14h", lim_e, m_l14);
      chk("R9", "rst pulse", {7'b0, rst_out_n}, {7'b0, m_cr == 0});
      chk("R10", "ci pulse", {7'b0, ci_out_n}, {7'b0, m_cc == 0});
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr = 0;
  endtask

  task automatic idle(int n, logic [7:0] a);
    repeat (n) begin @(posedge clk); #1; addr = a; end
  endtask

  task automatic sweep();
    idle(1, 8'h40); idle(1, 8'h41); idle(1, 8'h42);
    idle(1, 8'h43); idle(1, 8'h13); idle(1, 8'h14); idle(1, 8'h44);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    phase = "R1"; sweep();

    phase = "R2"; // mapped writes, R7 and R8 outputs
    wr_reg(8'h40, 8'h6F); wr_reg(8'h41, 8'hC9); wr_reg(8'h42, 8'hFF);
    wr_reg(8'h43, 8'h3C); wr_reg(8'h13, 8'h11); wr_reg(8'h14, 8'h22);
    sweep();
    wr_reg(8'h40, 8'h46); wr_reg(8'h41, 8'h48); wr_reg(8'h42, 8'h05);
    sweep();

    phase = "R11"; // unmapped
    wr_reg(8'h45, 8'hFF); wr_reg(8'h00, 8'hFF); wr_reg(8'hFF, 8'h55);
    idle(1, 8'h45); idle(1, 8'h00); idle(1, 8'hFF); sweep();

    phase = "R9";
    wr_reg(8'h40, 8'h11); idle(2, 8'h40);
    wr_reg(8'h40, 8'h11); idle(P + 3, 8'h40);

    phase = "R10";
    wr_reg(8'h44, 8'h80); idle(3, 8'h44);
    wr_reg(8'h44, 8'h80); wr_reg(8'h44, 8'h7F); idle(P + 3, 8'h44);

    phase = "R3"; // init with pulse bit also set
    wr_reg(8'h41, 8'hC8); wr_reg(8'h42, 8'h0A); wr_reg(8'h13, 8'h99);
    wr_reg(8'h40, 8'h97); sweep();

    phase = "R5";
    wr_reg(8'h13, 8'h11); wr_reg(8'h41, 8'h02);
    wr_reg(8'h13, 8'h77); wr_reg(8'h14, 8'h33);
    wr_reg(8'h41, 8'h00); wr_reg(8'h13, 8'h78); sweep();

    phase = "R6";
    wr_reg(8'h43, 8'h5A); wr_reg(8'h40, 8'h80); sweep();

    phase = "R4";
    wr_reg(8'h40, 8'h07); wr_reg(8'h41, 8'hCC); wr_reg(8'h42, 8'h0F);
    wr_reg(8'h13, 8'h01);
    @(posedge clk); #1 ext_n = 0;
    idle(1, 8'h40);
    wr_reg(8'h42, 8'h03); wr_reg(8'h43, 8'h44); idle(2, 8'h41);
    ext_n = 1; idle(1, 8'h42);
    wr_reg(8'h42, 8'h0C); sweep();

    phase = "R1";
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    sweep();
    wr_reg(8'h13, 8'hAB); idle(1, 8'h13);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog (step %s) act=hung exp=done", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule